// File: doc/BRIEF.md
# Strap-Configurable Clock Divider Controller

This block turns one master clock into two slower clocks: a system clock and a PWM master clock. Each one runs through its own power-of-two divider with ratios from 1 to 8. An 8-bit configuration register, reached through a single-address write/read port, sets both ratios. It also holds a gate bit for the system clock and a flag that powers down the oscillator.

One system-clock code does not name a fixed ratio. With that code, the ratio comes from a strap input that is captured while the active-low reset is held. A captured low gives divide-by-1 and a captured high gives divide-by-2. After reset the strap value is frozen. The strap pin itself is passed out unchanged, so other logic can use it for its normal job.

A ratio change, and a change of the gate bit, is held back until the current output period ends. As a result, neither output clock ever shows a shortened phase.

Top module: `clkdiv_strap_ctrl`

## Requirements
- R1: After reset the register reads 0x80: gate bit (bit 7) set, both divider codes 00, power-down bit (bit 2) clear. `osc_pdn_o` is 0.
- R2: A write with `wr_en_i` high stores `wr_data_i`. From the next clock on, `rd_data_o` returns bits 7:2 as written, and bits 1:0 read as zero.
- R3: When bit 7 is 0, `sys_clk_o` stays low.
- R4: The system-clock code in bits 6:5 sets the ratio: 01 divides by 2, 10 by 4, 11 by 8.
- R5: With system-clock code 00, the ratio follows the strap value sampled at the last clock edge with `rst_n_i` low: low gives divide-by-1, high gives divide-by-2.
- R6: Changes on `strap_i` after reset is released do not change the system-clock ratio. `strap_o` always equals `strap_i`.
- R7: The PWM code in bits 4:3 sets the ratio: 00 divides by 1, 01 by 2, 10 by 4, 11 by 8.
- R8: `osc_pdn_o` follows bit 2 from the clock after the write.
- R9: A divided output is high for N/2 master cycles and low for N/2 master cycles, where N is the ratio. Divide-by-1 passes the master clock through.
- R10: A new ratio or gate value takes effect only at the end of the current output period. No high or low phase is shorter than the shorter half-period of the old and new ratios.
- R11: While `rst_n_i` is low, writes are ignored, the register reads 0x80, and both clock outputs stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_n_i | input | 1 | Active-low reset, sampled synchronously |
| strap_i | input | 1 | Strap pin, captured during reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| sys_clk_o | output | 1 | Divided system clock |
| pwm_clk_o | output | 1 | Divided PWM master clock |
| osc_pdn_o | output | 1 | Oscillator power-down flag |
| strap_o | output | 1 | Strap pin passed through |

## Verification
Register read data and the power-down flag become valid one clock after the write edge. The bench checks them a few nanoseconds after that edge. A new ratio starts at the next period end, which is at most 8 master cycles plus one away. For this reason, steady-state waveforms are recorded only after a 20-cycle wait. Each output is sampled in the middle of both halves of every master cycle, and the bench measures the length of each complete high and low run. For a ratio switch, recording starts on the cycle after the write, so that the transition itself is captured.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  parameter int DIV_MAX_LOG = 3;
  localparam int DIV_LOG_W  = $clog2(DIV_MAX_LOG + 1);
  localparam int DIV_CNT_W  = (DIV_MAX_LOG > 0) ? DIV_MAX_LOG : 1;

  typedef struct packed {
    logic       sys_gate;
    logic [1:0] sys_code;
    logic [1:0] pwm_code;
    logic       osc_pdn;
    logic [1:0] rsvd;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{sys_gate: 1'b1, sys_code: 2'b00,
                                 pwm_code: 2'b00, osc_pdn: 1'b0, rsvd: 2'b00};

  function automatic logic [DIV_LOG_W-1:0] sys_log(input logic [1:0] code,
                                                    input logic strap);
    if (code == 2'b00) return DIV_LOG_W'(strap);
    return DIV_LOG_W'(code);
  endfunction

  function automatic logic [DIV_LOG_W-1:0] pwm_log(input logic [1:0] code);
    return DIV_LOG_W'(code);
  endfunction
endpackage

// File: rtl/clkdiv_cfg_reg.sv
module clkdiv_cfg_reg
  import clkdiv_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       strap_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output cfg_t       cfg_o,
  output logic       strap_cap_o
);
  cfg_t cfg_q;
  logic strap_q;

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      cfg_q   <= CFG_RESET;
      strap_q <= strap_i;
    end else if (wr_en_i) begin
      cfg_q      <= cfg_t'(wr_data_i);
      cfg_q.rsvd <= 2'b00;
    end
  end

  assign cfg_o       = cfg_q;
  assign strap_cap_o = strap_q;

  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    wr_en_i |=> (cfg_q == ($past(wr_data_i) & 8'hFC)));
  a_r6_strap_frozen: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $past(rst_n_i) |-> $stable(strap_q));
  a_r11_reset_value: assert property (@(posedge clk_i) disable iff (1'b0)
    !rst_n_i |=> (cfg_q == CFG_RESET));
endmodule

// File: rtl/clkdiv_gen.sv
module clkdiv_gen #(
  parameter int MAX_LOG = 3,
  parameter int LOG_W   = $clog2(MAX_LOG + 1),
  parameter int CNT_W   = (MAX_LOG > 0) ? MAX_LOG : 1
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             en_i,
  input  logic [LOG_W-1:0] log_i,
  output logic             clk_o
);
  localparam int CW = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [LOG_W-1:0] act_q;
  logic             en_q;
  logic             ph_q;
  logic [CW-1:0]    last_cnt, half_act, cnt_next;
  logic             at_end;

  assign last_cnt = (CW'(1) << act_q) - CW'(1);
  assign half_act = (CW'(1) << act_q) >> 1;
  assign cnt_next = {1'b0, cnt_q} + CW'(1);
  assign at_end   = ({1'b0, cnt_q} == last_cnt);

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
      act_q <= '0;
      en_q  <= 1'b0;
      ph_q  <= 1'b0;
    end else if (at_end) begin
      cnt_q <= '0;
      act_q <= log_i;
      en_q  <= en_i;
      ph_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      ph_q  <= (cnt_next < half_act);
    end
  end

  assign clk_o = en_q & ((act_q == '0) ? clk_i : ph_q);

  a_r10_ratio_held: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !at_end |=> ($stable(act_q) && $stable(en_q)));
  a_r9_count_bound: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ({1'b0, cnt_q} <= last_cnt));
  a_r9_phase_start: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (at_end && $past(rst_n_i)) |=> (ph_q && cnt_q == '0));
endmodule

// File: rtl/clkdiv_strap_ctrl.sv
module clkdiv_strap_ctrl
  import clkdiv_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       strap_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       sys_clk_o,
  output logic       pwm_clk_o,
  output logic       osc_pdn_o,
  output logic       strap_o
);
  cfg_t cfg;
  logic strap_cap;

  clkdiv_cfg_reg i_cfg (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .strap_i(strap_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .cfg_o(cfg), .strap_cap_o(strap_cap)
  );

  clkdiv_gen #(.MAX_LOG(DIV_MAX_LOG), .LOG_W(DIV_LOG_W), .CNT_W(DIV_CNT_W)) i_sys_div (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .en_i(cfg.sys_gate),
    .log_i(sys_log(cfg.sys_code, strap_cap)), .clk_o(sys_clk_o)
  );

  clkdiv_gen #(.MAX_LOG(DIV_MAX_LOG), .LOG_W(DIV_LOG_W), .CNT_W(DIV_CNT_W)) i_pwm_div (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .en_i(1'b1),
    .log_i(pwm_log(cfg.pwm_code)), .clk_o(pwm_clk_o)
  );

  assign rd_data_o = cfg;
  assign osc_pdn_o = cfg.osc_pdn;
  assign strap_o   = strap_i;

  a_r8_pdn_follows: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    wr_en_i |=> (osc_pdn_o == $past(wr_data_i[2])));
  a_r2_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    rd_data_o[1:0] == 2'b00);
endmodule

// File: tb/test_clkdiv_strap_ctrl.sv
module test_clkdiv_strap_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic sys_clk, pwm_clk, osc_pdn, strap_out;
  int total = 0, fails = 0;
  logic strap_cap_bench = 1'b0;
  logic smp [64];

  always #10 clk = ~clk;

  clkdiv_strap_ctrl i_clkdiv_strap_ctrl (
    .clk_i(clk), .rst_n_i(rst_n), .strap_i(strap), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .sys_clk_o(sys_clk),
    .pwm_clk_o(pwm_clk), .osc_pdn_o(osc_pdn), .strap_o(strap_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk); rst_n = 1'b0; strap = s;
    repeat (4) @(negedge clk);
    rst_n = 1'b1; strap_cap_bench = s;
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk); #2 wr_en = 1'b1; wr_data = d;
    @(posedge clk); #2 wr_en = 1'b0;
  endtask

  task automatic record(input bit pick_pwm);
    for (int i = 0; i < 32; i++) begin
      @(posedge clk); #5 smp[2*i] = pick_pwm ? pwm_clk : sys_clk;
      @(negedge clk); #5 smp[2*i+1] = pick_pwm ? pwm_clk : sys_clk;
    end
  endtask

  // Complete runs (between first and last transition) must lie within [lo,hi].
  function automatic bit runs_ok(input int lo, input int hi, output int bad);
    int start = -1, nruns = 0;
    bad = 0;
    for (int i = 1; i < 64; i++) begin
      if (smp[i] != smp[i-1]) begin
        if (start >= 0) begin
          nruns++;
          if ((i - start) < lo || (i - start) > hi) bad = i - start;
        end
        start = i;
      end
    end
    return (bad == 0) && (nruns >= 2);
  endfunction

  function automatic int sys_ratio(input logic [7:0] c, input logic s);
    if (!c[7]) return 0;
    if (c[6:5] == 2'b00) return s ? 2 : 1;
    return 1 << c[6:5];
  endfunction

  task automatic measure(input bit pick_pwm, input int n, input string req);
    int bad, highs;
    repeat (20) @(posedge clk);
    record(pick_pwm);
    if (n == 0) begin
      highs = 0;
      for (int i = 0; i < 64; i++) highs += int'(smp[i]);
      check(highs == 0, req, highs, 0);
    end else begin
      check(runs_ok(n, n, bad), req, bad, n);
    end
  endtask

  task automatic switch_check(input bit pick_pwm, input logic [7:0] from_c,
                              input logic [7:0] to_c, input int na, input int nb);
    int bad;
    write(from_c);
    repeat (20) @(posedge clk);
    write(to_c);
    record(pick_pwm);
    check(runs_ok(na < nb ? na : nb, na > nb ? na : nb, bad), "R10", bad, na < nb ? na : nb);
  endtask

  initial begin
    #4_000_000;
    total++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4711));
    // R11: during reset writes ignored and outputs low
    strap = 1'b1;
    repeat (3) @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h3C;
    @(posedge clk); #5;
    check(rd_data == 8'h80, "R11", rd_data, 8'h80);
    check(sys_clk == 1'b0 && pwm_clk == 1'b0, "R11", {sys_clk, pwm_clk}, 0);
    @(negedge clk); #5;
    check(sys_clk == 1'b0 && pwm_clk == 1'b0, "R11", {sys_clk, pwm_clk}, 0);
    wr_en = 1'b0;
    do_reset(1'b1);
    @(posedge clk); #2;
    // R1: defaults
    check(rd_data == 8'h80, "R1", rd_data, 8'h80);
    check(osc_pdn == 1'b0, "R1", osc_pdn, 0);
    measure(1'b1, 1, "R1 R7 pwm default");
    // R5: strap high -> /2
    measure(1'b0, 2, "R5 strap high");
    // R6: strap toggles after reset
    strap = 1'b0; #1;
    check(strap_out == 1'b0, "R6", strap_out, 0);
    measure(1'b0, 2, "R6 strap ignored");
    strap = 1'b1; #1;
    check(strap_out == 1'b1, "R6", strap_out, 1);
    // R5: strap low -> /1, R9 passthrough
    do_reset(1'b0);
    measure(1'b0, 1, "R5 R9 strap low");
    strap = 1'b1;
    measure(1'b0, 1, "R6 strap ignored");
    // R4/R7 directed
    write(8'hA0); measure(1'b0, 2, "R4 code01");
    write(8'hC0); measure(1'b0, 4, "R4 code10");
    write(8'hE0); measure(1'b0, 8, "R4 R9 code11");
    write(8'h88); measure(1'b1, 2, "R7 code01");
    write(8'h90); measure(1'b1, 4, "R7 code10");
    write(8'h98); measure(1'b1, 8, "R7 code11");
    // R3
    write(8'h60); measure(1'b0, 0, "R3 gate off");
    // R2/R8
    write(8'h07); #1;
    check(rd_data == 8'h04, "R2", rd_data, 8'h04);
    check(osc_pdn == 1'b1, "R8", osc_pdn, 1);
    // R10 switches
    switch_check(1'b0, 8'hE0, 8'hA0, 8, 2);
    switch_check(1'b1, 8'h80, 8'h98, 1, 8);
    switch_check(1'b1, 8'h90, 8'h80, 4, 1);
    switch_check(1'b0, 8'hC0, 8'hE4, 4, 8);
    // random configurations
    for (int k = 0; k < 10; k++) begin
      d = 8'($urandom);
      write(d); #1;
      check(rd_data == (d & 8'hFC), "R2 random", rd_data, d & 8'hFC);
      check(osc_pdn == d[2], "R8 random", osc_pdn, d[2]);
      measure(1'b0, sys_ratio(d, strap_cap_bench), "R4 R3 random");
      measure(1'b1, 1 << d[4:3], "R7 random");
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule